// File: doc/BRIEF.md
# Per-Channel Output Power Sequencer

This block sequences the power state of a bank of analog output channels. Each channel has three enables: one for its internal circuitry, one for its boost supply and one for the output driver. A requester names a channel, says whether it wants the channel up or down, and pulses a strobe. A power-down drops all three enables of that channel at once. A power-up is a timed two-step sequence. The internal and boost enables come on first. The output enable follows only after a settling wait, measured in microsecond ticks.

The block keeps a per-channel powered-down mask, which is all ones after reset. A request that asks for the state a channel is already in is discarded. While a settling wait runs, the block shows busy and drops every request. The enables are also offered packed into a per-channel control word, at the bit positions that the downstream converter control logic decodes.

Top module: `chan_power_seq`

## Requirements
- R1: After reset, `pd_mask` is all ones, every bit of `int_en`, `dcdc_en` and `out_en` is 0, and `busy` is 0.
- R2: A power-up request (`req_down`=0) for a powered-down channel, strobed while `busy` is 0, sets that channel's `int_en` and `dcdc_en`, clears its `pd_mask` bit and raises `busy` in the next cycle, with `out_en` still 0.
- R3: The output enable of the channel being powered up rises in the cycle after the SETTLE_TICKS-th `us_tick` counted from the cycle after acceptance, and `busy` falls in that same cycle. Ticks seen while idle have no effect.
- R4: A power-down request (`req_down`=1) for a powered-up channel, strobed while `busy` is 0, clears that channel's `int_en`, `dcdc_en` and `out_en` and sets its `pd_mask` bit, all in the next cycle.
- R5: A request that asks for the state the channel is already in (power-down for a set mask bit, power-up for a clear one) changes no output.
- R6: Every request strobed while `busy` is 1 is dropped and changes no output, both then and later.
- R7: `ctrl_word` holds one 9-bit word per channel, with channel i at bits [9i+8:9i]. Within a word, bit 8 is the internal enable, bit 6 the output enable and bit 4 the boost enable, and every other bit is 0.
- R8: A request for one channel never changes the enables or mask bit of any other channel.
- R9: A channel's `out_en` is never 1 unless its `int_en` and `dcdc_en` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| req_valid | input | 1 | Request strobe |
| req_chan | input | CH_W | Channel index of the request |
| req_down | input | 1 | 1 asks for power-down, 0 for power-up |
| int_en | output | NUM_CH | Internal circuitry enable per channel |
| dcdc_en | output | NUM_CH | Boost supply enable per channel |
| out_en | output | NUM_CH | Output driver enable per channel |
| pd_mask | output | NUM_CH | Powered-down flag per channel |
| busy | output | 1 | Settling wait in progress |
| ctrl_word | output | NUM_CH*9 | Packed per-channel control words |

## Verification
The bench drives the exact tick count of the settling wait. A design that counts one tick too many or too few, or counts idle ticks or the acceptance-cycle tick, turns the output on in the wrong cycle. Requests are strobed during a wait, including power-downs of the channel being sequenced. A design that queued or honoured them would drop enables or start a second timer. Repeated up and down requests for the same channel check that a redundant request does not restart the wait or raise busy. The packed word is compared bit by bit, so a swapped field position shows at once.

// File: rtl/chan_pwr_pkg.sv
package chan_pwr_pkg;
    // layout of one channel's control word, decoded downstream
    localparam int CTRL_W   = 9;
    localparam int BIT_INT  = 8;
    localparam int BIT_OUT  = 6;
    localparam int BIT_DCDC = 4;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_UP   = 2'd1,
        ACT_DOWN = 2'd2
    } pwr_act_e;
endpackage

// File: rtl/pwr_req_filter.sv
module pwr_req_filter
    import chan_pwr_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              req_valid,
    input  logic [CH_W-1:0]   req_chan,
    input  logic              req_down,
    input  logic              busy,
    input  logic [NUM_CH-1:0] pd_mask,
    output pwr_act_e          act,
    output logic [CH_W-1:0]   act_chan
);
    logic in_range;
    logic chan_down;

    always_comb begin
        in_range  = (32'(req_chan) < NUM_CH);
        chan_down = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (req_chan == CH_W'(i)) chan_down = pd_mask[i];
        end
        act      = ACT_NONE;
        act_chan = req_chan;
        if (req_valid && !busy && in_range) begin
            if (req_down && !chan_down)      act = ACT_DOWN;
            else if (!req_down && chan_down) act = ACT_UP;
        end
    end

    // R6: nothing is accepted while a wait runs
    always_comb begin
        if (busy) assert (act == ACT_NONE) else $error("p_busy_drops_r6");
    end
endmodule

// File: rtl/pwr_settle_timer.sv
module pwr_settle_timer #(
    parameter int SETTLE_TICKS = 200,
    parameter int CNT_W        = $clog2(SETTLE_TICKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic tick,
    output logic active,
    output logic done
);
    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] left;
    } tmr_t;

    tmr_t tm_d, tm_q;

    always_comb begin
        tm_d = tm_q;
        done = 1'b0;
        if (tm_q.active) begin
            if (tick) begin
                if (tm_q.left == CNT_W'(1)) begin
                    done        = 1'b1;
                    tm_d.active = 1'b0;
                    tm_d.left   = '0;
                end else begin
                    tm_d.left = tm_q.left - CNT_W'(1);
                end
            end
        end else if (start) begin
            tm_d.active = 1'b1;
            tm_d.left   = CNT_W'(SETTLE_TICKS);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tm_q <= '0;
        else        tm_q <= tm_d;
    end

    assign active = tm_q.active;

    // R3: a running count never sits at zero
    p_count_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tm_q.active |-> (tm_q.left != '0));
    // R3: an idle tick leaves the timer idle
    p_idle_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tm_q.active && !start) |=> !tm_q.active);
endmodule

// File: rtl/pwr_ctrl_pack.sv
module pwr_ctrl_pack
    import chan_pwr_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic [NUM_CH-1:0]        int_en,
    input  logic [NUM_CH-1:0]        dcdc_en,
    input  logic [NUM_CH-1:0]        out_en,
    output logic [NUM_CH*CTRL_W-1:0] ctrl_word
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_word
        logic [CTRL_W-1:0] w;
        always_comb begin
            w           = '0;
            w[BIT_INT]  = int_en[g];
            w[BIT_OUT]  = out_en[g];
            w[BIT_DCDC] = dcdc_en[g];
        end
        assign ctrl_word[g*CTRL_W +: CTRL_W] = w;
    end
endmodule

// File: rtl/chan_power_seq.sv
module chan_power_seq
    import chan_pwr_pkg::*;
#(
    parameter int NUM_CH       = 4,
    parameter int SETTLE_TICKS = 200,
    parameter int CH_W         = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     us_tick,
    input  logic                     req_valid,
    input  logic [CH_W-1:0]          req_chan,
    input  logic                     req_down,
    output logic [NUM_CH-1:0]        int_en,
    output logic [NUM_CH-1:0]        dcdc_en,
    output logic [NUM_CH-1:0]        out_en,
    output logic [NUM_CH-1:0]        pd_mask,
    output logic                     busy,
    output logic [NUM_CH*CTRL_W-1:0] ctrl_word
);
    localparam int CNT_W = $clog2(SETTLE_TICKS + 1);

    typedef struct packed {
        logic [NUM_CH-1:0] mask;
        logic [NUM_CH-1:0] ien;
        logic [NUM_CH-1:0] den;
        logic [NUM_CH-1:0] oen;
        logic [CH_W-1:0]   pend;
    } seq_t;

    seq_t     st_d, st_q;
    pwr_act_e act;
    logic [CH_W-1:0] act_chan;
    logic     tmr_active, tmr_done, tmr_start;

    pwr_req_filter #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_filter (
        .req_valid (req_valid),
        .req_chan  (req_chan),
        .req_down  (req_down),
        .busy      (tmr_active),
        .pd_mask   (st_q.mask),
        .act       (act),
        .act_chan  (act_chan)
    );

    assign tmr_start = (act == ACT_UP);

    pwr_settle_timer #(.SETTLE_TICKS(SETTLE_TICKS), .CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (tmr_start),
        .tick   (us_tick),
        .active (tmr_active),
        .done   (tmr_done)
    );

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_CH; i++) begin
            if (act_chan == CH_W'(i)) begin
                if (act == ACT_UP) begin
                    st_d.mask[i] = 1'b0;
                    st_d.ien[i]  = 1'b1;
                    st_d.den[i]  = 1'b1;
                end else if (act == ACT_DOWN) begin
                    st_d.mask[i] = 1'b1;
                    st_d.ien[i]  = 1'b0;
                    st_d.den[i]  = 1'b0;
                    st_d.oen[i]  = 1'b0;
                end
            end
            if (tmr_done && st_q.pend == CH_W'(i)) st_d.oen[i] = 1'b1;
        end
        if (act == ACT_UP) st_d.pend = act_chan;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign int_en  = st_q.ien;
    assign dcdc_en = st_q.den;
    assign out_en  = st_q.oen;
    assign pd_mask = st_q.mask;
    assign busy    = tmr_active;

    pwr_ctrl_pack #(.NUM_CH(NUM_CH)) u_pack (
        .int_en    (st_q.ien),
        .dcdc_en   (st_q.den),
        .out_en    (st_q.oen),
        .ctrl_word (ctrl_word)
    );

    // R6: a strobe during a wait leaves the mask untouched
    p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid) |=> $stable(pd_mask));

    // R3: output turns on only as the wait ends
    p_out_at_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (out_en == $past(out_en)));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        // R9: output driver needs both supplies
        p_out_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
            out_en[g] |-> (int_en[g] && dcdc_en[g]));
        // R2: mask bit tracks the internal enable
        p_mask_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
            pd_mask[g] == !int_en[g]);
        // R2: internal enable rises ahead of the output
        p_up_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(int_en[g]) |-> !out_en[g]);
        // R4: power-down drops every enable in one step
        p_down_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (!busy && req_valid && req_down && req_chan == CH_W'(g) && !pd_mask[g])
            |=> (pd_mask[g] && !int_en[g] && !dcdc_en[g] && !out_en[g]));
    end
endmodule

// File: tb/chan_power_seq_test.sv
module chan_power_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int NCH    = 4;
    localparam int SETTLE = 6;
    localparam int CW     = 2;
    localparam int WW     = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic us_tick = 1'b0, req_valid = 1'b0, req_down = 1'b0;
    logic [CW-1:0] req_chan = '0;
    logic [NCH-1:0] int_en, dcdc_en, out_en, pd_mask;
    logic busy;
    logic [NCH*WW-1:0] ctrl_word;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // reference state
    logic [NCH-1:0] m_mask, m_ien, m_den, m_oen;
    logic m_busy;
    int   m_cnt, m_pend;

    always #(CLK_PERIOD/2) clk = ~clk;

    chan_power_seq #(.NUM_CH(NCH), .SETTLE_TICKS(SETTLE)) uut (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .req_valid(req_valid),
        .req_chan(req_chan), .req_down(req_down), .int_en(int_en),
        .dcdc_en(dcdc_en), .out_en(out_en), .pd_mask(pd_mask), .busy(busy),
        .ctrl_word(ctrl_word)
    );

    function automatic logic [NCH*WW-1:0] pack_words(logic [NCH-1:0] ie,
            logic [NCH-1:0] de, logic [NCH-1:0] oe);
        logic [NCH*WW-1:0] w = '0;
        for (int i = 0; i < NCH; i++) begin
            w[i*WW+8] = ie[i];
            w[i*WW+6] = oe[i];
            w[i*WW+4] = de[i];
        end
        return w;
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // advance the reference by one clock, returns the requirement exercised
    function automatic string model_step(logic v, int ch, logic dn, logic tk);
        string tag = "R8";
        if (m_busy) begin
            if (v) tag = "R6";
            if (tk) begin
                if (m_cnt == 1) begin
                    m_oen[m_pend] = 1'b1;
                    m_busy = 1'b0;
                    tag = "R3";
                end else m_cnt--;
            end
        end else if (v) begin
            if (dn && !m_mask[ch]) begin
                m_mask[ch] = 1'b1; m_ien[ch] = 1'b0; m_den[ch] = 1'b0; m_oen[ch] = 1'b0;
                tag = "R4";
            end else if (!dn && m_mask[ch]) begin
                m_mask[ch] = 1'b0; m_ien[ch] = 1'b1; m_den[ch] = 1'b1;
                m_busy = 1'b1; m_cnt = SETTLE; m_pend = ch;
                tag = "R2";
            end else tag = "R5";
        end
        return tag;
    endfunction

    task automatic compare_all(string tag);
        chk({tag, " mask"}, 64'(pd_mask), 64'(m_mask));
        chk({tag, " int_en"}, 64'(int_en), 64'(m_ien));
        chk({tag, " dcdc_en"}, 64'(dcdc_en), 64'(m_den));
        chk({tag, " out_en"}, 64'(out_en), 64'(m_oen));
        chk({tag, " busy"}, 64'(busy), 64'(m_busy));
        chk("R7 ctrl_word", 64'(ctrl_word), 64'(pack_words(m_ien, m_den, m_oen)));
        chk("R9 out gated", 64'(out_en & ~(int_en & dcdc_en)), 64'd0);
    endtask

    // drive at negedge, model the edge, compare at next negedge
    task automatic cycle(logic v, int ch, logic dn, logic tk);
        string tag;
        req_valid = v; req_chan = CW'(ch); req_down = dn; us_tick = tk;
        tag = model_step(v, ch, dn, tk);
        @(negedge clk);
        compare_all(tag);
    endtask

    initial begin
        int seed;
        m_mask = '1; m_ien = '0; m_den = '0; m_oen = '0;
        m_busy = 0; m_cnt = 0; m_pend = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 mask", 64'(pd_mask), 64'hF);
        chk("R1 enables", 64'({int_en, dcdc_en, out_en}), 64'd0);
        chk("R1 busy", 64'(busy), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        compare_all("R1");

        // R3: ticks while idle do nothing
        repeat (4) cycle(0, 0, 0, 1);
        // R5: power-down of an already down channel
        cycle(1, 1, 1, 0);
        // R2: power up channel 2, tick on accept cycle is not counted
        cycle(1, 2, 0, 1);
        // R6: down request for the same channel during the wait
        cycle(1, 2, 1, 0);
        // R6: up request for another channel during the wait
        cycle(1, 0, 0, 1);
        for (int k = 0; k < SETTLE + 3; k++) cycle(0, 0, 0, (k % 2 == 0));
        // R6: the dropped up request did not start later
        chk("R6 chan0 still down", 64'(pd_mask[0]), 64'd1);
        // R5: up request for a channel already up, no new wait
        cycle(1, 2, 0, 0);
        chk("R5 no busy", 64'(busy), 64'd0);
        // R7: word of channel 2 reads 0x150
        chk("R7 word2", 64'(ctrl_word[2*WW +: WW]), 64'h150);
        // R4: power down channel 2
        cycle(1, 2, 1, 0);
        // R8: channel 3 up, then channel 0 up, channel 3 stays
        cycle(1, 3, 0, 0);
        repeat (SETTLE) cycle(0, 0, 0, 1);
        cycle(1, 0, 0, 0);
        repeat (SETTLE) cycle(0, 0, 0, 1);
        chk("R8 chan3 kept", 64'(out_en[3]), 64'd1);

        // random phase, fixed seed
        seed = 32'h5eed;
        void'($urandom(seed));
        for (int n = 0; n < 3000; n++) begin
            cycle(($urandom % 3) == 0, int'($urandom % NCH),
                  ($urandom % 2) == 1, ($urandom % 2) == 1);
        end
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule